// File: doc/BRIEF.md
# Tree Pseudo-LRU Cache Set

This block is one fully associative cache set of `WAYS` ways, where `WAYS` is a power of two (4 by default, 8 also used). Replacement follows a binary-tree pseudo-LRU policy. A tree of `WAYS-1` direction bits sits above the ways. Every access forces the bits on its own path to point away from the way it touched. A miss takes the way that the bits lead to, starting from the root. Invalid ways get no priority: the victim always comes from the tree walk. This is the tree-fill variant.

Each cycle the set can accept one request that carries a block tag. One cycle later it returns hit or miss and the way that was used. On a miss the tag is written into the victim way at the same clock edge. The stored tags, the valid bits and the tree bits are brought out so that a surrounding model can observe the replacement state. The tree bits are presented in pre-order.

Top module: `plru_set`

## Requirements
- R1: After reset every valid bit and every tree bit is 0, no response is pending, and `req_ready` is 1.
- R2: A request taken at a clock edge (`req_valid` and `req_ready` both high) gives `rsp_valid` high for exactly the following cycle. `rsp_valid` is low after any edge that took no request.
- R3: A request whose tag equals the tag of a valid way is a hit. The response carries `rsp_hit`=1 and that way's index, and no tag or valid bit changes.
- R4: On a miss the victim is found by walking from the root, where a tree bit of 0 selects the left child and 1 selects the right child. The request tag is written into that way and its valid bit is set, even when some other way is still invalid.
- R5: After any access, every tree bit on the path from the root to the accessed way is set to point away from that way, and all other tree bits keep their value. In `tree_o`, bit 0 is the root, then comes the left subtree in pre-order, then the right subtree.
- R6: Accessing the same way twice in a row leaves the tree bits as they were after the first access.
- R7: Starting from reset, a run of misses to distinct tags fills the ways in bit-reversed index order, and after `WAYS` misses the run starts again at way 0.
- R8: With 4 ways, a block that was just inserted is evicted by the third access that follows: two hits to selected other ways, then one miss.
- R9: While no request is taken, the tags, valid bits and tree bits stay unchanged, whatever value `req_tag` has.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is present |
| req_ready | output | 1 | The set can take a request (always high) |
| req_tag | input | TAG_W | Block tag of the request |
| rsp_valid | output | 1 | Response for the request taken at the previous edge |
| rsp_hit | output | 1 | 1 for a hit, 0 for a miss |
| rsp_way | output | $clog2(WAYS) | Way that hit or was filled |
| tags_o | output | WAYS*TAG_W | Stored tags, way w in bits [w*TAG_W +: TAG_W] |
| valid_o | output | WAYS | Valid bit of each way |
| tree_o | output | WAYS-1 | Tree bits in pre-order, root at bit 0 |

## Verification
The response, the new tags, the new valid bits and the new tree bits are all updated at the same edge that takes the request. All of them are therefore due one cycle after the request is driven. The bench drives inputs on the falling edge and samples one time unit after the next rising edge. That sample sees the response together with the updated state. A second sample, one cycle later with no request, checks that `rsp_valid` has dropped and that the state holds. A second instance with 8 ways checks the order in which a run of misses fills the ways.

// File: rtl/plru_set.sv
module plru_set #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [TAG_W-1:0]         req_tag,
  output logic                     rsp_valid,
  output logic                     rsp_hit,
  output logic [$clog2(WAYS)-1:0]  rsp_way,
  output logic [WAYS*TAG_W-1:0]    tags_o,
  output logic [WAYS-1:0]          valid_o,
  output logic [WAYS-2:0]          tree_o
);

  localparam int DEPTH = $clog2(WAYS);
  localparam int NODES = WAYS - 1;
  localparam int WAY_W = DEPTH;

  // pre-order position of heap node (level, pos)
  function automatic int preorder_idx(input int lvl, input int pos);
    int idx;
    idx = 0;
    for (int j = 0; j < DEPTH; j++)
      if (j < lvl) begin
        if (((pos >> (lvl - 1 - j)) & 1) == 1) idx += (1 << (DEPTH - 1 - j));
        else                                    idx += 1;
      end
    return idx;
  endfunction

  logic [TAG_W-1:0] tag_q [WAYS];
  logic [WAYS-1:0]  vld_q;
  logic [NODES-1:0] tree_h, tree_nxt;
  logic [WAYS-1:0]  match, leaf_sel;
  logic [WAY_W-1:0] hit_way, victim, use_way;
  logic             hit, fire;

  assign req_ready = 1'b1;
  assign fire      = req_valid & req_ready;
  assign hit       = |match;
  assign use_way   = hit ? hit_way : victim;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [DEPTH-1:0] step_ok;
    assign match[w] = vld_q[w] && (tag_q[w] == req_tag);
    assign tags_o[w*TAG_W +: TAG_W] = tag_q[w];
    for (genvar l = 0; l < DEPTH; l++) begin : g_lvl
      localparam int H = (1 << l) - 1 + (w >> (DEPTH - l));
      localparam int D = (w >> (DEPTH - 1 - l)) & 1;
      assign step_ok[l] = (tree_h[H] == 1'(D));
    end
    assign leaf_sel[w] = &step_ok;
  end

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (match[w]) hit_way = WAY_W'(w);
  end

  always_comb begin
    victim = '0;
    for (int w = 0; w < WAYS; w++)
      if (leaf_sel[w]) victim = WAY_W'(w);
  end

  for (genvar l = 0; l < DEPTH; l++) begin : g_node_lvl
    for (genvar p = 0; p < (1 << l); p++) begin : g_node
      localparam int H   = (1 << l) - 1 + p;
      localparam int PRE = preorder_idx(l, p);
      logic on_path;
      assign on_path     = ((use_way >> (DEPTH - l)) == WAY_W'(p));
      assign tree_nxt[H] = on_path ? ~use_way[DEPTH-1-l] : tree_h[H];
      assign tree_o[PRE] = tree_h[H];
    end
  end

  assign valid_o = vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q     <= '0;
      tree_h    <= '0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_way   <= '0;
    end else begin
      rsp_valid <= fire;
      if (fire) begin
        rsp_hit <= hit;
        rsp_way <= use_way;
        tree_h  <= tree_nxt;
        if (!hit) vld_q[victim] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fire && !hit) tag_q[victim] <= req_tag;
  end

endmodule

// File: rtl/plru_set_chk.sv
module plru_set_chk #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic                    req_ready,
  input logic [TAG_W-1:0]        req_tag,
  input logic                    rsp_valid,
  input logic                    rsp_hit,
  input logic [$clog2(WAYS)-1:0] rsp_way,
  input logic [WAYS*TAG_W-1:0]   tags_o,
  input logic [WAYS-1:0]         valid_o,
  input logic [WAYS-2:0]         tree_o
);

  logic fire;
  assign fire = req_valid && req_ready;

  a_r2_rsp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rsp_valid);

  a_r2_no_rsp_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !rsp_valid);

  a_r3_hit_keeps_tags: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> ($stable(tags_o) && $stable(valid_o) && valid_o[rsp_way]));

  a_r4_miss_fills_way: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (valid_o[rsp_way] && tags_o[rsp_way*TAG_W +: TAG_W] == $past(req_tag)));

  a_r9_idle_holds_state: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> ($stable(tree_o) && $stable(valid_o) && $stable(tags_o)));

  a_r1_ready_high: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready);

endmodule

bind plru_set plru_set_chk #(.WAYS(WAYS), .TAG_W(TAG_W)) u_chk (.*);

// File: tb/plru_set_bench.sv
module plru_set_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [7:0] req_tag = '0;
  logic       rsp_valid, rsp_hit;
  logic [1:0] rsp_way;
  logic [31:0] tags_o;
  logic [3:0] valid_o;
  logic [2:0] tree_o;

  logic       v8 = 1'b0;
  logic [7:0] t8 = '0;
  logic       rdy8, rv8, rh8;
  logic [2:0] rw8;
  logic [63:0] tg8;
  logic [7:0] vl8;
  logic [6:0] tr8;

  plru_set #(.WAYS(4), .TAG_W(8)) u_plru_set (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_tag(req_tag), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
    .tags_o(tags_o), .valid_o(valid_o), .tree_o(tree_o));

  plru_set #(.WAYS(8), .TAG_W(8)) u_plru_set8 (
    .clk(clk), .rst_n(rst_n), .req_valid(v8), .req_ready(rdy8),
    .req_tag(t8), .rsp_valid(rv8), .rsp_hit(rh8), .rsp_way(rw8),
    .tags_o(tg8), .valid_o(vl8), .tree_o(tr8));

  int checks = 0;
  int errors = 0;

  task automatic check(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic access(input logic [7:0] tag);
    @(negedge clk);
    req_valid = 1'b1;
    req_tag   = tag;
    @(posedge clk);
    #1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_rsp(input string rq, input logic hit, input logic [1:0] way, input logic [2:0] tree);
    check(rq, "rsp_valid", 64'(rsp_valid), 64'd1);
    check(rq, "rsp_hit", 64'(rsp_hit), 64'(hit));
    check(rq, "rsp_way", 64'(rsp_way), 64'(way));
    check(rq, "tree", 64'(tree_o), 64'(tree));
  endtask

  task automatic t_reset;
    check("R1", "valid", 64'(valid_o), 64'd0);
    check("R1", "tree", 64'(tree_o), 64'd0);
    check("R1", "rsp_valid", 64'(rsp_valid), 64'd0);
    check("R1", "ready", 64'(req_ready), 64'd1);
  endtask

  // tree vectors below are {right, left, root}
  task automatic t_fill;
    access(8'h0A); expect_rsp("R4", 1'b0, 2'd0, 3'b011);
    access(8'h0C); expect_rsp("R4", 1'b0, 2'd2, 3'b110);
    check("R4", "way1 still invalid", 64'(valid_o[1]), 64'd0);
    access(8'h0B); expect_rsp("R5", 1'b0, 2'd1, 3'b101);
    access(8'h0D); expect_rsp("R5", 1'b0, 2'd3, 3'b000);
    check("R4", "tags", 64'(tags_o), 64'h0D0C0B0A);
    check("R4", "valid", 64'(valid_o), 64'hF);
  endtask

  task automatic t_hit_repeat;
    access(8'h0A); expect_rsp("R3", 1'b1, 2'd0, 3'b011);
    check("R3", "tags", 64'(tags_o), 64'h0D0C0B0A);
    access(8'h0A); expect_rsp("R6", 1'b1, 2'd0, 3'b011);
  endtask

  task automatic t_sequence;
    access(8'h0E); expect_rsp("R5", 1'b0, 2'd2, 3'b110);
    check("R5", "tags e", 64'(tags_o), 64'h0D0E0B0A);
    access(8'h0A); expect_rsp("R5", 1'b1, 2'd0, 3'b111);
    access(8'h0F); expect_rsp("R5", 1'b0, 2'd3, 3'b010);
    check("R5", "tags f", 64'(tags_o), 64'h0F0E0B0A);
  endtask

  task automatic t_fast_evict;
    access(8'h0E); expect_rsp("R8", 1'b1, 2'd2, 3'b110);
    access(8'h0A); expect_rsp("R8", 1'b1, 2'd0, 3'b111);
    access(8'h11); expect_rsp("R8", 1'b0, 2'd3, 3'b010);
    access(8'h0F); check("R8", "evicted block misses", 64'(rsp_hit), 64'd0);
  endtask

  task automatic t_idle;
    logic [2:0]  tr;
    logic [3:0]  vl;
    logic [31:0] tg;
    tr = tree_o; vl = valid_o; tg = tags_o;
    @(negedge clk);
    req_tag = 8'h0A;
    @(posedge clk); #1;
    check("R2", "rsp_valid idle", 64'(rsp_valid), 64'd0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); req_tag = 8'(8'h30 + i);
    end
    @(posedge clk); #1;
    check("R9", "tree", 64'(tree_o), 64'(tr));
    check("R9", "valid", 64'(valid_o), 64'(vl));
    check("R9", "tags", 64'(tags_o), 64'(tg));
  endtask

  function automatic logic [2:0] bitrev3(input int n);
    logic [2:0] v;
    v = 3'(n);
    return {v[0], v[1], v[2]};
  endfunction

  task automatic t_order8;
    for (int i = 0; i < 9; i++) begin
      @(negedge clk); v8 = 1'b1; t8 = 8'(8'h40 + i);
      @(posedge clk); #1;
      check("R7", "miss", 64'(rh8), 64'd0);
      check("R7", "way", 64'(rw8), 64'(bitrev3(i % 8)));
      @(negedge clk); v8 = 1'b0;
    end
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_fill();
    t_hit_repeat();
    t_sequence();
    t_idle();
    t_fast_evict();
    t_order8();
    finish_run();
  end
endmodule